// File: doc/BRIEF.md
# Protection Entry Register Bank

This block is the machine-mode register file that stores the sixteen memory-protection entries of a 32-bit hart. Each entry has one configuration byte (read, write and execute permissions, a match mode and a lock bit) and one address register. Software reaches the bank through a single CSR port. Configuration bytes are packed four to a CSR word, and each address register has a CSR of its own. The bank drives every configuration byte and every address value out as flat vectors, which a separate permission checker consumes.

Writes follow write-any-read-legal rules. A reserved permission combination is repaired as it is written, and reserved bits are never stored. A bad write raises no exception. Setting an entry's lock bit freezes that entry until reset. When the locked entry uses top-of-range matching, the lock also freezes the address register of the entry below it, because that register supplies the entry's lower bound. Any access from a lower privilege level, or to an address outside the implemented registers, is flagged as illegal and changes nothing.

Top module: `prot_csr_bank`

## Requirements
- R1: Reset (rst_n low) clears every configuration byte, including its lock bit, and every address register to zero.
- R2: Configuration CSRs decode at 0x3A0 to 0x3A3, with entry i held in CSR 0x3A0+i/4 at bits 8*(i mod 4)+7 down to 8*(i mod 4). Address CSRs decode at 0x3B0 to 0x3BF and hold physical address bits 33:2. A valid read returns the addressed contents on csr_rdata in the same cycle.
- R3: Any access with priv_lvl other than 2'b11 (machine) raises csr_illegal, returns zero read data and changes no state.
- R4: An access to any address outside the two windows (for example 0x39F, 0x3A4 or 0x3C0) raises csr_illegal and changes no state.
- R5: In a configuration byte, bit 0 is read, bit 1 is write, bit 2 is execute, bits 4:3 are the match mode (00 off, 01 top-of-range, 10 four-byte, 11 power-of-two) and bit 7 is the lock. A written byte with write=1 and read=0 is stored with write cleared, and its other bits are kept.
- R6: Bits 6:5 of every configuration byte always read as zero, whatever was written.
- R7: While an entry's lock bit is set, writes to its configuration byte are ignored. The other byte lanes of the same packed write still update.
- R8: While an entry's lock bit is set, writes to its address register are ignored, even when its match mode is off.
- R9: While entry i is locked with match mode top-of-range, writes to the address register of entry i-1 are ignored. Entry 0 protects no other register, and an unlocked top-of-range entry protects nothing.
- R10: A lock is released only by reset. After reset, writes to a previously locked entry take effect.
- R11: cfg_flat (byte i = entry i) and addr_flat (word i = entry i) show the stored state and change on the clock edge that completes a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hart reset |
| csr_valid | input | 1 | CSR access strobe |
| csr_we | input | 1 | Access is a write |
| csr_addr | input | 12 | CSR address |
| csr_wdata | input | 32 | Write data |
| priv_lvl | input | 2 | Privilege of the access, 2'b11 is machine |
| csr_rdata | output | 32 | Read data for the addressed CSR |
| csr_illegal | output | 1 | Access is not permitted or targets no register |
| cfg_flat | output | 128 | All configuration bytes, entry i in byte i |
| addr_flat | output | 512 | All address registers, entry i in word i |

## Verification
Two functions meet in one cycle when a single packed configuration write both hits a locked byte lane and carries a reserved write-without-read value in the unlocked lanes. Lane masking and legalization then have to act side by side. The bench provokes this by writing such a word to a CSR that holds one locked entry. It then reads the CSR back and expects the locked byte unchanged and every other byte repaired. A second pairing is a top-of-range lock together with a write to the register below it, and the bench judges this through read-back of that register.

// File: rtl/prot_csr_pkg.sv
package prot_csr_pkg;

    localparam logic [1:0] PRIV_M = 2'b11;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'd0,
        MATCH_TOR   = 2'd1,
        MATCH_NA4   = 2'd2,
        MATCH_NAPOT = 2'd3
    } match_e;

    typedef struct packed {
        logic       lock;
        logic [1:0] rsvd;
        match_e     mode;
        logic       x;
        logic       w;
        logic       r;
    } ent_cfg_t;

    // Repair a raw byte into a legal configuration value.
    function automatic ent_cfg_t legalize_cfg(input logic [7:0] raw);
        ent_cfg_t c;
        c      = ent_cfg_t'(raw);
        c.rsvd = 2'b00;
        if (c.w && !c.r) begin
            c.w = 1'b0;
        end
        return c;
    endfunction

endpackage

// File: rtl/prot_csr_decode.sv
module prot_csr_decode #(
    parameter int unsigned ADDR_W    = 12,
    parameter int unsigned N_ENTRY   = 16,
    parameter int unsigned N_CFG     = 4,
    parameter logic [11:0] CFG_BASE  = 12'h3A0,
    parameter logic [11:0] ADDR_BASE = 12'h3B0,
    localparam int unsigned CFG_IDX_W = $clog2(N_CFG),
    localparam int unsigned ENT_IDX_W = $clog2(N_ENTRY)
) (
    input  logic                 csr_valid,
    input  logic                 csr_we,
    input  logic [ADDR_W-1:0]    csr_addr,
    input  logic [1:0]           priv_lvl,
    output logic                 sel_cfg,
    output logic                 sel_addr,
    output logic                 wr_cfg,
    output logic                 wr_addr,
    output logic [CFG_IDX_W-1:0] cfg_idx,
    output logic [ENT_IDX_W-1:0] addr_idx,
    output logic                 illegal
);
    import prot_csr_pkg::*;

    localparam logic [ADDR_W-1:0] N_CFG_L   = ADDR_W'(N_CFG);
    localparam logic [ADDR_W-1:0] N_ENT_L   = ADDR_W'(N_ENTRY);

    logic [ADDR_W-1:0] off_cfg;
    logic [ADDR_W-1:0] off_addr;
    logic              in_cfg;
    logic              in_addr;
    logic              priv_ok;

    always_comb begin
        off_cfg  = csr_addr - CFG_BASE;
        off_addr = csr_addr - ADDR_BASE;
        in_cfg   = off_cfg < N_CFG_L;
        in_addr  = off_addr < N_ENT_L;
        priv_ok  = priv_lvl == PRIV_M;
        sel_cfg  = csr_valid && priv_ok && in_cfg;
        sel_addr = csr_valid && priv_ok && in_addr;
        wr_cfg   = sel_cfg && csr_we;
        wr_addr  = sel_addr && csr_we;
        cfg_idx  = off_cfg[CFG_IDX_W-1:0];
        addr_idx = off_addr[ENT_IDX_W-1:0];
        illegal  = csr_valid && (!priv_ok || !(in_cfg || in_addr));
    end

endmodule

// File: rtl/prot_lock_map.sv
module prot_lock_map #(
    parameter int unsigned N_ENTRY = 16
) (
    input  prot_csr_pkg::ent_cfg_t [N_ENTRY-1:0] cfg,
    output logic [N_ENTRY-1:0]                   cfg_frozen,
    output logic [N_ENTRY-1:0]                   addr_frozen
);
    import prot_csr_pkg::*;

    for (genvar i = 0; i < N_ENTRY; i++) begin : g_ent
        assign cfg_frozen[i] = cfg[i].lock;
        if (i < N_ENTRY - 1) begin : g_has_upper
            // Upper neighbour in top-of-range mode uses this register as its base.
            assign addr_frozen[i] = cfg[i].lock
                                  || (cfg[i+1].lock && (cfg[i+1].mode == MATCH_TOR));
        end else begin : g_top
            assign addr_frozen[i] = cfg[i].lock;
        end
    end

endmodule

// File: rtl/prot_cfg_lane.sv
module prot_cfg_lane (
    input  prot_csr_pkg::ent_cfg_t cur,
    input  logic [7:0]             wbyte,
    input  logic                   lane_we,
    input  logic                   frozen,
    output prot_csr_pkg::ent_cfg_t nxt
);
    import prot_csr_pkg::*;

    always_comb begin
        if (lane_we && !frozen) begin
            nxt = legalize_cfg(wbyte);
        end else begin
            nxt = cur;
        end
    end

endmodule

// File: rtl/prot_csr_bank.sv
module prot_csr_bank #(
    parameter int unsigned N_ENTRY   = 16,
    parameter int unsigned XLEN      = 32,
    parameter int unsigned ADDR_W    = 12,
    parameter logic [11:0] CFG_BASE  = 12'h3A0,
    parameter logic [11:0] ADDR_BASE = 12'h3B0
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    csr_valid,
    input  logic                    csr_we,
    input  logic [ADDR_W-1:0]       csr_addr,
    input  logic [XLEN-1:0]         csr_wdata,
    input  logic [1:0]              priv_lvl,
    output logic [XLEN-1:0]         csr_rdata,
    output logic                    csr_illegal,
    output logic [8*N_ENTRY-1:0]    cfg_flat,
    output logic [XLEN*N_ENTRY-1:0] addr_flat
);
    import prot_csr_pkg::*;

    localparam int unsigned LANES     = XLEN / 8;
    localparam int unsigned N_CFG     = N_ENTRY / LANES;
    localparam int unsigned CFG_IDX_W = $clog2(N_CFG);
    localparam int unsigned ENT_IDX_W = $clog2(N_ENTRY);

    typedef struct packed {
        ent_cfg_t [N_ENTRY-1:0]            cfg;
        logic     [N_ENTRY-1:0][XLEN-1:0]  addr;
    } bank_t;

    bank_t st_d;
    bank_t st_q;

    logic                 sel_cfg;
    logic                 sel_addr;
    logic                 wr_cfg;
    logic                 wr_addr;
    logic [CFG_IDX_W-1:0] cfg_idx;
    logic [ENT_IDX_W-1:0] addr_idx;
    logic [N_ENTRY-1:0]   cfg_frozen;
    logic [N_ENTRY-1:0]   addr_frozen;
    logic [N_ENTRY-1:0]   lane_we;
    ent_cfg_t [N_ENTRY-1:0]          lane_nxt;
    logic [N_CFG-1:0][XLEN-1:0]      cfg_word;

    prot_csr_decode #(
        .ADDR_W    (ADDR_W),
        .N_ENTRY   (N_ENTRY),
        .N_CFG     (N_CFG),
        .CFG_BASE  (CFG_BASE),
        .ADDR_BASE (ADDR_BASE)
    ) u_dec (
        .csr_valid (csr_valid),
        .csr_we    (csr_we),
        .csr_addr  (csr_addr),
        .priv_lvl  (priv_lvl),
        .sel_cfg   (sel_cfg),
        .sel_addr  (sel_addr),
        .wr_cfg    (wr_cfg),
        .wr_addr   (wr_addr),
        .cfg_idx   (cfg_idx),
        .addr_idx  (addr_idx),
        .illegal   (csr_illegal)
    );

    prot_lock_map #(
        .N_ENTRY (N_ENTRY)
    ) u_lock (
        .cfg         (st_q.cfg),
        .cfg_frozen  (cfg_frozen),
        .addr_frozen (addr_frozen)
    );

    for (genvar i = 0; i < N_ENTRY; i++) begin : g_lane
        localparam int unsigned WORD = i / LANES;
        localparam int unsigned POS  = i % LANES;

        assign lane_we[i] = wr_cfg && (cfg_idx == CFG_IDX_W'(WORD));
        assign cfg_word[WORD][8*POS +: 8] = st_q.cfg[i];

        prot_cfg_lane u_lane (
            .cur     (st_q.cfg[i]),
            .wbyte   (csr_wdata[8*POS +: 8]),
            .lane_we (lane_we[i]),
            .frozen  (cfg_frozen[i]),
            .nxt     (lane_nxt[i])
        );
    end

    // Next-state computation.
    always_comb begin
        st_d     = st_q;
        st_d.cfg = lane_nxt;
        if (wr_addr && !addr_frozen[addr_idx]) begin
            st_d.addr[addr_idx] = csr_wdata;
        end
    end

    // Read path.
    always_comb begin
        csr_rdata = '0;
        if (sel_cfg) begin
            csr_rdata = cfg_word[cfg_idx];
        end else if (sel_addr) begin
            csr_rdata = st_q.addr[addr_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_flat  = st_q.cfg;
    assign addr_flat = st_q.addr;

endmodule

// File: rtl/prot_csr_bank_chk.sv
module prot_csr_bank_chk #(
    parameter int unsigned N_ENTRY = 16,
    parameter int unsigned XLEN    = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    csr_valid,
    input logic [1:0]              priv_lvl,
    input logic                    csr_illegal,
    input logic [XLEN-1:0]         csr_rdata,
    input logic [8*N_ENTRY-1:0]    cfg_flat,
    input logic [XLEN*N_ENTRY-1:0] addr_flat
);

    assert_non_m_illegal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && priv_lvl != 2'b11) |-> (csr_illegal && csr_rdata == '0));

    assert_illegal_no_effect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_valid && csr_illegal) |=> ($stable(cfg_flat) && $stable(addr_flat)));

    for (genvar i = 0; i < N_ENTRY; i++) begin : g_chk
        assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_flat[8*i+5 +: 2] == 2'b00);

        assert_no_w_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !(cfg_flat[8*i+1] && !cfg_flat[8*i]));

        assert_locked_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_flat[8*i+7] |=> $stable(cfg_flat[8*i +: 8]));

        assert_locked_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
            cfg_flat[8*i+7] |=> $stable(addr_flat[XLEN*i +: XLEN]));

        if (i < N_ENTRY - 1) begin : g_tor
            assert_tor_base_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_flat[8*(i+1)+7] && cfg_flat[8*(i+1)+3 +: 2] == 2'b01)
                |=> $stable(addr_flat[XLEN*i +: XLEN]));
        end
    end

endmodule

bind prot_csr_bank prot_csr_bank_chk #(
    .N_ENTRY (N_ENTRY),
    .XLEN    (XLEN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_valid   (csr_valid),
    .priv_lvl    (priv_lvl),
    .csr_illegal (csr_illegal),
    .csr_rdata   (csr_rdata),
    .cfg_flat    (cfg_flat),
    .addr_flat   (addr_flat)
);

// File: tb/sim_prot_csr_bank.sv
module sim_prot_csr_bank;

    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;
    localparam logic [1:0] PM = 2'b11;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         csr_valid = 1'b0;
    logic         csr_we = 1'b0;
    logic [11:0]  csr_addr = '0;
    logic [31:0]  csr_wdata = '0;
    logic [1:0]   priv_lvl = 2'b11;
    logic [31:0]  csr_rdata;
    logic         csr_illegal;
    logic [127:0] cfg_flat;
    logic [511:0] addr_flat;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    // kind: 0 read data + illegal, 1 addr_flat word, 2 cfg_flat byte, 3 illegal only
    typedef struct {
        int          kind;
        int          idx;
        logic [31:0] exp_val;
        logic        exp_ill;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    prot_csr_bank u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .csr_valid   (csr_valid),
        .csr_we      (csr_we),
        .csr_addr    (csr_addr),
        .csr_wdata   (csr_wdata),
        .priv_lvl    (priv_lvl),
        .csr_rdata   (csr_rdata),
        .csr_illegal (csr_illegal),
        .cfg_flat    (cfg_flat),
        .addr_flat   (addr_flat)
    );

    task automatic push(input int kind, input int idx, input logic [31:0] v,
                        input logic ill, input string tag);
        item_t it;
        it.kind = kind; it.idx = idx; it.exp_val = v; it.exp_ill = ill; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic rd(input logic [11:0] a, input logic [1:0] pv,
                      input logic [31:0] exp_v, input logic exp_i, input string tag);
        @(negedge clk);
        csr_valid = 1'b1; csr_we = 1'b0; csr_addr = a; csr_wdata = '0; priv_lvl = pv;
        push(0, 0, exp_v, exp_i, tag);
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [1:0] pv,
                      input logic exp_i, input string tag);
        @(negedge clk);
        csr_valid = 1'b1; csr_we = 1'b1; csr_addr = a; csr_wdata = d; priv_lvl = pv;
        push(3, 0, '0, exp_i, tag);
    endtask

    task automatic chk_flat(input int kind, input int idx, input logic [31:0] v,
                            input string tag);
        @(negedge clk);
        csr_valid = 1'b0; csr_we = 1'b0;
        push(kind, idx, v, 1'b0, tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        csr_valid = 1'b0; csr_we = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: compares queued expectations a quarter period after each falling edge.
    initial begin
        item_t it;
        logic [31:0] got;
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/4);
            while (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                case (it.kind)
                    0: begin
                        n_checks++;
                        if (csr_rdata !== it.exp_val || csr_illegal !== it.exp_ill) begin
                            n_errors++;
                            $display("FAIL %s: rdata=%h ill=%b expected rdata=%h ill=%b",
                                     it.tag, csr_rdata, csr_illegal, it.exp_val, it.exp_ill);
                        end
                    end
                    1: begin
                        n_checks++;
                        got = addr_flat[32*it.idx +: 32];
                        if (got !== it.exp_val) begin
                            n_errors++;
                            $display("FAIL %s: addr_flat[%0d]=%h expected %h",
                                     it.tag, it.idx, got, it.exp_val);
                        end
                    end
                    2: begin
                        n_checks++;
                        got = {24'h0, cfg_flat[8*it.idx +: 8]};
                        if (got !== it.exp_val) begin
                            n_errors++;
                            $display("FAIL %s: cfg_flat byte %0d=%h expected %h",
                                     it.tag, it.idx, got, it.exp_val);
                        end
                    end
                    default: begin
                        n_checks++;
                        if (csr_illegal !== it.exp_ill) begin
                            n_errors++;
                            $display("FAIL %s: illegal=%b expected %b",
                                     it.tag, csr_illegal, it.exp_ill);
                        end
                    end
                endcase
            end
        end
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not finish, got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(12'h3A0, PM, 32'h0, 1'b0, "R1 cfg0 after reset");
        rd(12'h3A3, PM, 32'h0, 1'b0, "R1 cfg3 after reset");
        rd(12'h3B0, PM, 32'h0, 1'b0, "R1 addr0 after reset");
        rd(12'h3BF, PM, 32'h0, 1'b0, "R1 addr15 after reset");

        // R2 / R11: address register write and flat output timing
        wr(12'h3B5, 32'hDEADBEEF, PM, 1'b0, "R2 write addr5");
        chk_flat(1, 5, 32'hDEADBEEF, "R11 addr_flat word 5 after write");
        rd(12'h3B5, PM, 32'hDEADBEEF, 1'b0, "R2 read addr5");

        // R5 / R6: legalization per lane
        wr(12'h3A1, 32'h7F021D63, PM, 1'b0, "R5 write cfg1");
        rd(12'h3A1, PM, 32'h1F001D03, 1'b0, "R5 R6 read cfg1 legalized");
        chk_flat(2, 4, 32'h03, "R6 R11 cfg_flat byte 4");
        chk_flat(2, 6, 32'h00, "R5 cfg_flat byte 6 W-only cleared");

        // R3: lower privilege
        wr(12'h3B5, 32'h0, 2'b00, 1'b1, "R3 user write flagged");
        rd(12'h3B5, 2'b01, 32'h0, 1'b1, "R3 supervisor read flagged");
        rd(12'h3B5, PM, 32'hDEADBEEF, 1'b0, "R3 addr5 unchanged");

        // R4: out-of-window addresses
        wr(12'h3A4, 32'hFFFFFFFF, PM, 1'b1, "R4 write 0x3A4 flagged");
        wr(12'h3C0, 32'hFFFFFFFF, PM, 1'b1, "R4 write 0x3C0 flagged");
        rd(12'h39F, PM, 32'h0, 1'b1, "R4 read 0x39F flagged");
        rd(12'h3A1, PM, 32'h1F001D03, 1'b0, "R4 cfg1 unchanged");

        // R7 / R8: lock with mode off on entry 9
        wr(12'h3B9, 32'h11111111, PM, 1'b0, "R8 prefill addr9");
        wr(12'h3B8, 32'h22222222, PM, 1'b0, "R9 prefill addr8");
        wr(12'h3A2, 32'h00008100, PM, 1'b0, "R7 lock entry9");
        chk_flat(2, 9, 32'h81, "R2 entry9 in cfg2 bits 15:8");
        wr(12'h3A2, 32'h03030303, PM, 1'b0, "R7 packed write over lock");
        rd(12'h3A2, PM, 32'h03038103, 1'b0, "R7 locked lane held others updated");
        wr(12'h3A2, 32'h0202FF02, PM, 1'b0, "R5 R7 lock and legalize same write");
        rd(12'h3A2, PM, 32'h00008100, 1'b0, "R5 R7 combined result");
        wr(12'h3B9, 32'h0000AAAA, PM, 1'b0, "R8 write locked addr9");
        rd(12'h3B9, PM, 32'h11111111, 1'b0, "R8 addr9 held with mode off");
        wr(12'h3B8, 32'h00003333, PM, 1'b0, "R9 write addr8 below non-TOR lock");
        rd(12'h3B8, PM, 32'h00003333, 1'b0, "R9 addr8 writable");

        // R9: locked top-of-range entry 13 protects addr12
        wr(12'h3BC, 32'h00000100, PM, 1'b0, "R9 prefill addr12");
        wr(12'h3BD, 32'h00000200, PM, 1'b0, "R9 prefill addr13");
        wr(12'h3A3, 32'h00008900, PM, 1'b0, "R9 lock entry13 TOR");
        wr(12'h3BC, 32'h00005555, PM, 1'b0, "R9 write base addr12");
        rd(12'h3BC, PM, 32'h00000100, 1'b0, "R9 addr12 held");
        wr(12'h3BD, 32'h00007777, PM, 1'b0, "R8 write addr13");
        rd(12'h3BD, PM, 32'h00000200, 1'b0, "R8 addr13 held");
        wr(12'h3BB, 32'h00000044, PM, 1'b0, "R9 write addr11");
        rd(12'h3BB, PM, 32'h00000044, 1'b0, "R9 addr11 writable");
        wr(12'h3A3, 32'h00000000, PM, 1'b0, "R7 clear cfg3");
        rd(12'h3A3, PM, 32'h00008900, 1'b0, "R7 entry13 held");

        // R9: unlocked TOR protects nothing; entry 0 TOR lock does not wrap
        wr(12'h3A0, 32'h09000088, PM, 1'b0, "R9 entry3 TOR unlocked entry0 TOR locked");
        wr(12'h3B2, 32'h00000066, PM, 1'b0, "R9 write addr2");
        rd(12'h3B2, PM, 32'h00000066, 1'b0, "R9 addr2 writable under unlocked TOR");
        wr(12'h3B0, 32'h00000012, PM, 1'b0, "R8 write addr0");
        rd(12'h3B0, PM, 32'h00000000, 1'b0, "R8 addr0 held");
        wr(12'h3BF, 32'h00000099, PM, 1'b0, "R9 write addr15");
        rd(12'h3BF, PM, 32'h00000099, 1'b0, "R9 addr15 not protected by entry0");

        // R10 / R1: reset releases locks
        do_reset();
        rd(12'h3A2, PM, 32'h0, 1'b0, "R1 R10 cfg2 cleared");
        rd(12'h3BD, PM, 32'h0, 1'b0, "R1 addr13 cleared");
        wr(12'h3BD, 32'h00000077, PM, 1'b0, "R10 write addr13 after reset");
        rd(12'h3BD, PM, 32'h00000077, 1'b0, "R10 addr13 writable");
        wr(12'h3A2, 32'h00000300, PM, 1'b0, "R10 write entry9 after reset");
        rd(12'h3A2, PM, 32'h00000300, 1'b0, "R10 entry9 writable");

        @(negedge clk);
        csr_valid = 1'b0; csr_we = 1'b0;
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule